// File: doc/BRIEF.md
# I2C Interrupt Flag and Vector Unit

This unit collects the single-cycle event pulses from an I2C controller core and turns them into an interrupt. The pulses are arbitration lost, no-acknowledge, access ready, receive ready, transmit ready, stop seen and addressed as slave. Each pulse sets a sticky flag. Software enables events one at a time through an enable register. One request line goes high while any flag is both set and enabled.

A vector register returns a small code for the most urgent flag that is set and enabled. Reading the vector also acknowledges that flag, so software can service events by reading the vector over and over until it returns zero. Software can also clear flags directly by writing ones to the flag register. The flag register additionally shows two live signals from the core: receive shift register full and bus busy.

The register port is a plain control port, not a stream, so it has no back-pressure. A read or write is accepted in every cycle in which its enable is high. Read data appears one cycle after the read enable.

Top module: `i2c_irq_vector`

## Requirements
- R1: After reset all flags are zero, the enable register is zero, `irq_o` is low and `rdata_o` is zero.
- R2: An event pulse on `evt_i[k]` sets flag k. Flag k is shown at status bit k. The source order is 0 arbitration lost, 1 no-acknowledge, 2 access ready, 3 receive ready, 4 transmit ready, 5 stop seen, 6 addressed as slave. A flag stays set until it is cleared.
- R3: A status read shows `rs_full_i` at bit 11 and `bus_busy_i` at bit 12, sampled at the read edge. All other unused status bits read 0.
- R4: Writing the status register clears each flag whose write bit is 1. Flags whose write bit is 0 are left unchanged.
- R5: Writing the enable register loads bits 6:0, one enable per source in the R2 order. Reading it returns those bits, with the upper bits 0.
- R6: A vector read returns source index + 1 (1 to 7) for the lowest-index flag that is both set and enabled, or 0 if there is none.
- R7: A vector read clears only the flag that it reports. The next vector read returns the next pending source.
- R8: A disabled event still sets its flag, but it never appears in the vector and never raises `irq_o`.
- R9: `irq_o` is high exactly when some flag is both set and enabled. It reflects the state right after the edge that changed a flag or an enable.
- R10: If an event and a clear of the same flag (by a status write or by a vector read) arrive at the same edge, the flag ends up set.
- R11: Select codes are 0 status, 1 enable, 2 vector, 3 unused. Reads of code 3 return 0. Writes to codes 2 and 3 have no effect. `rdata_o` changes only on a read. A read at the same edge as a write returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 7 | Event pulses from the controller core, one bit per source |
| rs_full_i | input | 1 | Live receive-shift-full state |
| bus_busy_i | input | 1 | Live bus-busy state |
| reg_sel_i | input | 2 | Register select |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid the cycle after `rd_en_i` |
| irq_o | output | 1 | Interrupt request |

## Verification
Flags and enables change at the edge that samples the stimulus. `irq_o` is decoded from those registers, so it is due right after that same edge. `rdata_o` is due one edge after the read strobe and holds the register state from before that edge. The bench drives every input on the falling edge and updates its reference model at the rising edge. It compares `irq_o` and any read data 1 ns after the rising edge, so each check sees exactly the edge it models.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_ENAB = 2'd1,
    SEL_VECT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/i2c_irq_flags.sv
module i2c_irq_flags #(
  parameter int unsigned SRC_N = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] set_i,
  input  logic [SRC_N-1:0] clr_i,
  output logic [SRC_N-1:0] flag_o
);
  for (genvar i = 0; i < SRC_N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)         flag_o[i] <= 1'b0;
      else if (set_i[i])  flag_o[i] <= 1'b1;
      else if (clr_i[i])  flag_o[i] <= 1'b0;
    end

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> flag_o[i]);
    // R4
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !flag_o[i]);
    // R2
    rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_o[i]) |-> $past(set_i[i]));
  end
endmodule

// File: rtl/i2c_irq_prio.sv
module i2c_irq_prio #(
  parameter int unsigned SRC_N  = 7,
  parameter int unsigned CODE_W = $clog2(SRC_N + 1)
) (
  input  logic [SRC_N-1:0]  pend_i,
  output logic [CODE_W-1:0] code_o,
  output logic [SRC_N-1:0]  code_oh_o
);
  always_comb begin
    code_o = '0;
    for (int i = SRC_N - 1; i >= 0; i--) begin
      if (pend_i[i]) code_o = CODE_W'(i + 1);
    end
  end

  always_comb begin
    for (int i = 0; i < SRC_N; i++) begin
      code_oh_o[i] = (code_o == CODE_W'(i + 1));
    end
  end
endmodule

// File: rtl/i2c_irq_vector.sv
module i2c_irq_vector
  import i2c_irq_pkg::*;
#(
  parameter int unsigned SRC_N      = 7,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned RSFULL_POS = 11,
  parameter int unsigned BUSY_POS   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_N-1:0]  evt_i,
  input  logic              rs_full_i,
  input  logic              bus_busy_i,
  input  logic [1:0]        reg_sel_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int unsigned CODE_W = $clog2(SRC_N + 1);

  reg_sel_e           sel;
  logic [SRC_N-1:0]   flags;
  logic [SRC_N-1:0]   enab_q;
  logic [SRC_N-1:0]   pend;
  logic [SRC_N-1:0]   clr;
  logic [SRC_N-1:0]   code_oh;
  logic [CODE_W-1:0]  vec_code;
  logic [DATA_W-1:0]  stat_word;

  assign sel  = reg_sel_e'(reg_sel_i);
  assign pend = flags & enab_q;

  i2c_irq_prio #(.SRC_N(SRC_N), .CODE_W(CODE_W)) u_prio (
    .pend_i    (pend),
    .code_o    (vec_code),
    .code_oh_o (code_oh)
  );

  always_comb begin
    clr = '0;
    if (wr_en_i && sel == SEL_STAT) clr = clr | wdata_i[SRC_N-1:0];
    if (rd_en_i && sel == SEL_VECT) clr = clr | code_oh;
  end

  i2c_irq_flags #(.SRC_N(SRC_N)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (evt_i),
    .clr_i  (clr),
    .flag_o (flags)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                          enab_q <= '0;
    else if (wr_en_i && sel == SEL_ENAB) enab_q <= wdata_i[SRC_N-1:0];
  end

  always_comb begin
    stat_word             = '0;
    stat_word[SRC_N-1:0]  = flags;
    stat_word[RSFULL_POS] = rs_full_i;
    stat_word[BUSY_POS]   = bus_busy_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata_o <= '0;
    else if (rd_en_i) begin
      case (sel)
        SEL_STAT: rdata_o <= stat_word;
        SEL_ENAB: rdata_o <= DATA_W'(enab_q);
        SEL_VECT: rdata_o <= DATA_W'(vec_code);
        default:  rdata_o <= '0;
      endcase
    end
  end

  assign irq_o = |pend;

  // R9
  irq_has_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (vec_code != '0));
  // R8
  vec_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((code_oh & ~enab_q) == '0));
  // R6
  vec_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_code != '0) |-> ((flags & enab_q & (code_oh - 1'b1)) == '0));
  // R7
  vec_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && sel == SEL_VECT && ((evt_i & code_oh) == '0)) |=> ((flags & $past(code_oh)) == '0));
  // R11
  unused_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && sel == SEL_NONE) |=> (rdata_o == '0));
  // R5
  enab_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && sel == SEL_ENAB) |=> (enab_q == $past(wdata_i[SRC_N-1:0])));
endmodule

// File: tb/test_i2c_irq_vector.sv
module test_i2c_irq_vector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  evt = '0;
  logic        rs_full = 1'b0;
  logic        busy = 1'b0;
  logic [1:0]  sel = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [6:0] m_flags = '0;
  logic [6:0] m_enab = '0;

  always #2.5 clk = ~clk;

  i2c_irq_vector i_i2c_irq_vector (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .rs_full_i(rs_full),
    .bus_busy_i(busy), .reg_sel_i(sel), .wr_en_i(wr), .rd_en_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [2:0] exp_code(logic [6:0] f, logic [6:0] e);
    for (int i = 0; i < 7; i++) if (f[i] && e[i]) return 3'(i + 1);
    return 3'd0;
  endfunction

  function automatic logic [15:0] exp_read(logic [1:0] s, logic lf, logic lb);
    logic [15:0] w;
    w = '0;
    case (s)
      2'd0: begin w[6:0] = m_flags; w[11] = lf; w[12] = lb; end
      2'd1: w[6:0] = m_enab;
      2'd2: w[2:0] = exp_code(m_flags, m_enab);
      default: w = '0;
    endcase
    return w;
  endfunction

  task automatic check(string tag, string what, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic step(logic [6:0] e, logic lf, logic lb, logic [1:0] s,
                      logic w, logic r, logic [15:0] d, string tag);
    logic [15:0] exp_rd;
    logic [6:0]  c;
    logic [2:0]  code;
    @(negedge clk);
    evt = e; rs_full = lf; busy = lb; sel = s; wr = w; rd = r; wdata = d;
    @(posedge clk);
    exp_rd = exp_read(s, lf, lb);
    code = exp_code(m_flags, m_enab);
    c = '0;
    if (w && s == 2'd0) c = c | d[6:0];
    if (r && s == 2'd2 && code != 0) c[code - 1] = 1'b1;
    m_flags = (m_flags & ~c) | e;
    if (w && s == 2'd1) m_enab = d[6:0];
    #1;
    if (r) check(tag, "rdata", rdata, exp_rd);
    check(tag, "irq", 16'(irq), 16'(|(m_flags & m_enab)));
    evt = '0; wr = 1'b0; rd = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs at reset
    check("R1", "rdata at reset", rdata, 16'h0);
    check("R1", "irq at reset", 16'(irq), 16'h0);
    @(negedge clk); rst_n = 1'b1;
    step('0, 0, 0, 2'd0, 0, 1, 0, "R1");
    step('0, 0, 0, 2'd1, 0, 1, 0, "R1");
    step('0, 0, 0, 2'd2, 0, 1, 0, "R1");

    // R8: a disabled event sets its flag but stays quiet
    step(7'h10, 0, 0, 2'd0, 0, 0, 0, "R8");
    step('0, 0, 0, 2'd2, 0, 1, 0, "R8");
    step('0, 0, 0, 2'd0, 0, 1, 0, "R2");

    // R4: write-one-to-clear, writing zero leaves flags unchanged
    step('0, 0, 0, 2'd0, 1, 0, 16'h0000, "R4");
    step('0, 0, 0, 2'd0, 0, 1, 0, "R4");
    step('0, 0, 0, 2'd0, 1, 0, 16'h0010, "R4");
    step('0, 0, 0, 2'd0, 0, 1, 0, "R4");

    // R5 and R6/R7: enable all, fire all, drain the vector in priority order
    step('0, 0, 0, 2'd1, 1, 0, 16'hFFFF, "R5");
    step('0, 0, 0, 2'd1, 0, 1, 0, "R5");
    step(7'h7F, 0, 0, 2'd0, 0, 0, 0, "R9");
    for (int k = 0; k < 8; k++) step('0, 0, 0, 2'd2, 0, 1, 0, "R7");

    // R3: live bits
    step('0, 1, 0, 2'd0, 0, 1, 0, "R3");
    step('0, 0, 1, 2'd0, 0, 1, 0, "R3");

    // R10: event wins over a status clear and over a vector acknowledge
    step(7'h04, 0, 0, 2'd0, 1, 0, 16'h0004, "R10");
    step('0, 0, 0, 2'd0, 0, 1, 0, "R10");
    step(7'h04, 0, 0, 2'd2, 0, 1, 0, "R10");
    step('0, 0, 0, 2'd2, 0, 1, 0, "R10");

    // R11: unused select, writes to vector ignored, read before write
    step('0, 0, 0, 2'd3, 0, 1, 0, "R11");
    step(7'h02, 0, 0, 2'd2, 1, 0, 16'hFFFF, "R11");
    step('0, 0, 0, 2'd3, 1, 0, 16'hFFFF, "R11");
    step('0, 0, 0, 2'd0, 0, 1, 0, "R11");
    step('0, 0, 0, 2'd1, 1, 1, 16'h0005, "R11");
    step('0, 0, 0, 2'd1, 0, 1, 0, "R11");

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [6:0] e;
      e = 7'($urandom & $urandom & $urandom);
      step(e, 1'($urandom), 1'($urandom), 2'($urandom), ($urandom % 4) == 0,
           1'($urandom), 16'($urandom), "R6");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule